// File: doc/BRIEF.md
# Panel Switch and Pot Scanner

This block watches a front panel made of switch rows, read through external parallel-in/serial-out shift registers, and of potentiometers, read through an analog multiplexer feeding two 8-bit converter results. Two panels are served at once: a main panel and an auxiliary panel. They share the row/channel select lines, the load line and the serial clock. Each has its own serial data input and its own conversion input.

The block keeps an image of every byte it reads. After reset it scans everything once and stores the values without raising an interrupt. It then streams the whole image to the host as a fixed eleven-byte message: ten data bytes and a terminator. From then on it rescans without end. Any byte that differs from its stored copy replaces that copy and is announced through an interrupt. The interrupt carries the byte's index and its new value and stays up until the host acknowledges it. The host uses the message to build its picture of the panel, then follows the interrupts to keep that picture current.

Top module: `panel_scanner`

## Requirements
- R1: Before each switch row is loaded, `row_sel` is set to the row number. It holds steady through the load and all eight shift clocks. Rows are visited in order 0 to SW_ROWS-1, followed by the pot channels, and the pass then repeats.
- R2: `load_n` goes low for exactly one clock per switch row. `ser_clk` stays low while `load_n` is low.
- R3: Each switch row gets exactly eight `ser_clk` pulses, high and low one clock each. `ser_main` and `ser_aux` are sampled as `ser_clk` rises. The first bit sampled becomes bit 7 of the row byte.
- R4: For a pot channel, `mux_off` goes low with `row_sel` equal to the channel number. `adc_main` and `adc_aux` are captured one clock later. Outside pot reads `mux_off` is high.
- R5: Image index 2r holds main row r and index 2r+1 holds auxiliary row r. Pot channel c is at index 2*SW_ROWS+2c (main) and 2*SW_ROWS+2c+1 (auxiliary). When a new reading differs from its stored byte, the store is updated, `chg_irq` rises, and `chg_idx`/`chg_val` give that index and value. The main byte of a slot is compared before its auxiliary byte.
- R6: `chg_irq`, `chg_idx` and `chg_val` hold until a cycle with `irq_ack` high, and `chg_irq` is low after that clock. While the interrupt is pending, comparison pauses, so a later difference is reported after the acknowledge rather than lost.
- R7: After reset and the first full scan, the block sends eleven bytes on `msg_data` over a valid/ready handshake: image bytes 0 to 9 in index order, then 8'hFF. A byte stays valid and unchanged until accepted. `msg_valid` is low once the terminator is taken. `chg_irq` stays low until the message is done.
- R8: While `rst_n` is low, `load_n`=1, `ser_clk`=0, `mux_off`=1, `chg_irq`=0 and `msg_valid`=0. The stored image clears, and the startup scan and message repeat after release.
- R9: A full rescan with no input change raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_main | input | 1 | Serial data from main panel shift register |
| ser_aux | input | 1 | Serial data from auxiliary panel shift register |
| adc_main | input | 8 | Main panel pot conversion result |
| adc_aux | input | 8 | Auxiliary panel pot conversion result |
| row_sel | output | 3 | Switch row / pot channel select |
| mux_off | output | 1 | Pot multiplexer disable, high = off |
| load_n | output | 1 | Low = parallel load, high = shift |
| ser_clk | output | 1 | Shift clock to both shift registers |
| msg_data | output | 8 | Startup message byte |
| msg_valid | output | 1 | Message byte available |
| msg_ready | input | 1 | Host accepts message byte |
| chg_irq | output | 1 | Change interrupt |
| irq_ack | input | 1 | Host acknowledge, clears the interrupt |
| chg_idx | output | 4 | Image index of the changed byte |
| chg_val | output | 8 | New value of the changed byte |

## Verification
The bench plays the external shift registers and the pot multiplexer. Its model loads on the load line and shifts on the serial clock, so a wrong bit order or a ninth or seventh clock would show up as corrupted row bytes, and a wrong select would read the wrong row. Changes to main and auxiliary bytes of the same row are made together, which catches a design that reports only one of them or loses the second while the first is pending. A pending interrupt is left unacknowledged for many scans, to catch a design that drops it or overwrites its index. The message is taken under alternating backpressure, which exposes skipped or repeated bytes. A reset in mid-run checks that the startup message is rebuilt from fresh readings.

// File: rtl/panel_scan_pkg.sv
package panel_scan_pkg;

  localparam int SEL_W = 3;
  localparam logic [7:0] EOM_BYTE = 8'hFF;

  typedef enum logic [2:0] {
    RD_IDLE, RD_SEL, RD_LOAD, RD_LO, RD_HI, RD_SETTLE, RD_DONE
  } rd_state_e;

  typedef enum logic [1:0] {PH_INIT, PH_REPORT, PH_RUN} phase_e;

  typedef enum logic [2:0] {
    C_ISSUE, C_READ, C_CMP_M, C_CMP_A, C_REPORT
  } ctl_state_e;

  // image position of one of the two bytes a slot produces
  function automatic int unsigned img_index(int unsigned slot, bit aux);
    return slot * 2 + (aux ? 1 : 0);
  endfunction

  // slots 0..sw_rows-1 are switch rows, the rest are pot channels
  function automatic bit slot_is_pot(int unsigned slot, int unsigned sw_rows);
    return slot >= sw_rows;
  endfunction

  function automatic int unsigned slot_addr(int unsigned slot, int unsigned sw_rows);
    return (slot < sw_rows) ? slot : slot - sw_rows;
  endfunction

endpackage

// File: rtl/ps_slot_reader.sv
module ps_slot_reader
  import panel_scan_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_pot,
  input  logic [SEL_W-1:0]  addr,
  input  logic              ser_main,
  input  logic              ser_aux,
  input  logic [DATA_W-1:0] adc_main,
  input  logic [DATA_W-1:0] adc_aux,
  output logic [SEL_W-1:0]  sel,
  output logic              mux_off,
  output logic              load_n,
  output logic              ser_clk,
  output logic              done,
  output logic [DATA_W-1:0] byte_m,
  output logic [DATA_W-1:0] byte_a
);

  localparam int BCNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int RCNT_W = $clog2(DATA_W + 1);
  localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(DATA_W - 1);

  rd_state_e         st_q;
  logic [SEL_W-1:0]  sel_q;
  logic              off_q, ld_q, clk_q, pot_q;
  logic [BCNT_W-1:0] bcnt_q;
  logic [DATA_W-1:0] bm_q, ba_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RD_IDLE;
      sel_q  <= '0;
      off_q  <= 1'b1;
      ld_q   <= 1'b1;
      clk_q  <= 1'b0;
      pot_q  <= 1'b0;
      bcnt_q <= '0;
      bm_q   <= '0;
      ba_q   <= '0;
    end else begin
      unique case (st_q)
        RD_IDLE: if (start) begin
          sel_q <= addr;
          off_q <= !is_pot;
          pot_q <= is_pot;
          st_q  <= is_pot ? RD_SETTLE : RD_SEL;
        end
        RD_SEL: begin
          ld_q <= 1'b0;
          st_q <= RD_LOAD;
        end
        RD_LOAD: begin
          ld_q   <= 1'b1;
          bcnt_q <= '0;
          st_q   <= RD_LO;
        end
        RD_LO: begin
          clk_q <= 1'b1;
          bm_q  <= {bm_q[DATA_W-2:0], ser_main};
          ba_q  <= {ba_q[DATA_W-2:0], ser_aux};
          st_q  <= RD_HI;
        end
        RD_HI: begin
          clk_q  <= 1'b0;
          bcnt_q <= bcnt_q + 1'b1;
          st_q   <= (bcnt_q == LAST_BIT) ? RD_DONE : RD_LO;
        end
        RD_SETTLE: begin
          bm_q <= adc_main;
          ba_q <= adc_aux;
          st_q <= RD_DONE;
        end
        RD_DONE: begin
          off_q <= 1'b1;
          st_q  <= RD_IDLE;
        end
        default: st_q <= RD_IDLE;
      endcase
    end
  end

  assign sel     = sel_q;
  assign mux_off = off_q;
  assign load_n  = ld_q;
  assign ser_clk = clk_q;
  assign done    = (st_q == RD_DONE);
  assign byte_m  = bm_q;
  assign byte_a  = ba_q;

  // observation of the serial clock seen at the pins
  logic              clk_d;
  logic              clk_rise_evt;
  logic [RCNT_W-1:0] rise_cnt;
  assign clk_rise_evt = clk_q && !clk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_d    <= 1'b0;
      rise_cnt <= '0;
    end else begin
      clk_d <= clk_q;
      if (!ld_q)             rise_cnt <= '0;
      else if (clk_rise_evt) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  // R2
  load_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ld_q) |=> ld_q);
  // R2
  no_clock_in_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_q |-> !clk_q);
  // R3
  clock_high_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_q) |=> !clk_q);
  // R1
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_q || clk_q) |-> $stable(sel_q));
  // R3
  eight_clocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !pot_q) |-> rise_cnt == RCNT_W'(DATA_W));

endmodule

// File: rtl/ps_image_store.sv
module ps_image_store #(
  parameter int N      = 10,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data
);

  logic [DATA_W-1:0] mem [N];

  for (genvar g = 0; g < N; g++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 mem[g] <= '0;
      else if (wr_en && wr_idx == IDX_W'(g))      mem[g] <= wr_data;
    end
  end

  assign rd_a_data = (rd_a_idx < IDX_W'(N)) ? mem[rd_a_idx] : '0;
  assign rd_b_data = (rd_b_idx < IDX_W'(N)) ? mem[rd_b_idx] : '0;

endmodule

// File: rtl/ps_change_notify.sv
module ps_change_notify #(
  parameter int IDX_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              raise,
  input  logic [IDX_W-1:0]  raise_idx,
  input  logic [DATA_W-1:0] raise_val,
  input  logic              ack,
  output logic              irq,
  output logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] val
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq <= 1'b0;
      idx <= '0;
      val <= '0;
    end else if (raise) begin
      irq <= 1'b1;
      idx <= raise_idx;
      val <= raise_val;
    end else if (ack) begin
      irq <= 1'b0;
    end
  end

  // R6
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack) |=> irq);
  // R6
  chg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack) |=> ($stable(idx) && $stable(val)));
  // R5
  raise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    raise |=> (irq && val == $past(raise_val) && idx == $past(raise_idx)));

endmodule

// File: rtl/ps_report_tx.sv
module ps_report_tx #(
  parameter int          N      = 10,
  parameter int          IDX_W  = 4,
  parameter int          DATA_W = 8,
  parameter logic [7:0]  EOM    = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              ready,
  output logic [IDX_W-1:0]  img_idx,
  input  logic [DATA_W-1:0] img_data,
  output logic              valid,
  output logic [DATA_W-1:0] data,
  output logic              finished
);

  logic [IDX_W-1:0] k_q;
  logic             at_end;

  assign at_end   = (k_q == IDX_W'(N));
  assign valid    = active;
  assign img_idx  = k_q;
  assign data     = at_end ? DATA_W'(EOM) : img_data;
  assign finished = active && ready && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 k_q <= '0;
    else if (active && ready)   k_q <= at_end ? '0 : k_q + 1'b1;
  end

  // R7
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(data)));

endmodule

// File: rtl/panel_scanner.sv
module panel_scanner
  import panel_scan_pkg::*;
#(
  parameter int SW_ROWS = 4,
  parameter int POT_CH  = 1,
  parameter int DATA_W  = 8,
  localparam int SLOTS  = SW_ROWS + POT_CH,
  localparam int IMG_N  = 2 * SLOTS,
  localparam int IDX_W  = $clog2(IMG_N + 1),
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_main,
  input  logic              ser_aux,
  input  logic [DATA_W-1:0] adc_main,
  input  logic [DATA_W-1:0] adc_aux,
  output logic [SEL_W-1:0]  row_sel,
  output logic              mux_off,
  output logic              load_n,
  output logic              ser_clk,
  output logic [DATA_W-1:0] msg_data,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic              chg_irq,
  input  logic              irq_ack,
  output logic [IDX_W-1:0]  chg_idx,
  output logic [DATA_W-1:0] chg_val
);

  phase_e            phase_q;
  ctl_state_e        cs_q;
  logic [SLOT_W-1:0] slot_q;

  logic              rd_start, rd_done, cur_pot;
  logic [SEL_W-1:0]  cur_addr;
  logic [DATA_W-1:0] rd_bm, rd_ba;

  logic              in_cmp, cmp_aux, is_init, cmp_stall, cmp_diff;
  logic              img_wr, raise_evt, last_slot, tx_finished;
  logic [IDX_W-1:0]  cmp_idx, tx_idx;
  logic [DATA_W-1:0] new_byte, stored_byte, tx_byte;

  assign cur_pot   = slot_is_pot(32'(slot_q), SW_ROWS);
  assign cur_addr  = SEL_W'(slot_addr(32'(slot_q), SW_ROWS));
  assign rd_start  = (cs_q == C_ISSUE);
  assign in_cmp    = (cs_q == C_CMP_M) || (cs_q == C_CMP_A);
  assign cmp_aux   = (cs_q == C_CMP_A);
  assign cmp_idx   = IDX_W'(img_index(32'(slot_q), cmp_aux));
  assign new_byte  = cmp_aux ? rd_ba : rd_bm;
  assign is_init   = (phase_q == PH_INIT);
  assign cmp_stall = in_cmp && !is_init && chg_irq;
  assign cmp_diff  = (new_byte != stored_byte);
  assign img_wr    = in_cmp && !cmp_stall && (is_init || cmp_diff);
  assign raise_evt = in_cmp && !cmp_stall && !is_init && cmp_diff;
  assign last_slot = (slot_q == SLOT_W'(SLOTS - 1));

  ps_slot_reader #(.DATA_W(DATA_W)) u_reader (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (rd_start),
    .is_pot   (cur_pot),
    .addr     (cur_addr),
    .ser_main (ser_main),
    .ser_aux  (ser_aux),
    .adc_main (adc_main),
    .adc_aux  (adc_aux),
    .sel      (row_sel),
    .mux_off  (mux_off),
    .load_n   (load_n),
    .ser_clk  (ser_clk),
    .done     (rd_done),
    .byte_m   (rd_bm),
    .byte_a   (rd_ba)
  );

  ps_image_store #(.N(IMG_N), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_image (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (img_wr),
    .wr_idx    (cmp_idx),
    .wr_data   (new_byte),
    .rd_a_idx  (cmp_idx),
    .rd_a_data (stored_byte),
    .rd_b_idx  (tx_idx),
    .rd_b_data (tx_byte)
  );

  ps_change_notify #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_notify (
    .clk       (clk),
    .rst_n     (rst_n),
    .raise     (raise_evt),
    .raise_idx (cmp_idx),
    .raise_val (new_byte),
    .ack       (irq_ack),
    .irq       (chg_irq),
    .idx       (chg_idx),
    .val       (chg_val)
  );

  ps_report_tx #(.N(IMG_N), .IDX_W(IDX_W), .DATA_W(DATA_W), .EOM(EOM_BYTE)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (cs_q == C_REPORT),
    .ready    (msg_ready),
    .img_idx  (tx_idx),
    .img_data (tx_byte),
    .valid    (msg_valid),
    .data     (msg_data),
    .finished (tx_finished)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_INIT;
      cs_q    <= C_ISSUE;
      slot_q  <= '0;
    end else begin
      unique case (cs_q)
        C_ISSUE: cs_q <= C_READ;
        C_READ:  if (rd_done) cs_q <= C_CMP_M;
        C_CMP_M: if (!cmp_stall) cs_q <= C_CMP_A;
        C_CMP_A: if (!cmp_stall) begin
          if (last_slot) begin
            slot_q <= '0;
            if (is_init) begin
              phase_q <= PH_REPORT;
              cs_q    <= C_REPORT;
            end else begin
              cs_q <= C_ISSUE;
            end
          end else begin
            slot_q <= slot_q + 1'b1;
            cs_q   <= C_ISSUE;
          end
        end
        C_REPORT: if (tx_finished) begin
          phase_q <= PH_RUN;
          cs_q    <= C_ISSUE;
        end
        default: cs_q <= C_ISSUE;
      endcase
    end
  end

  // R7
  quiet_before_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_RUN) |-> !chg_irq);
  // R7
  msg_only_in_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (phase_q == PH_REPORT));
  // R4
  pot_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mux_off |-> load_n);

endmodule

// File: tb/sim_panel_scanner.sv
module sim_panel_scanner;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ser_main, ser_aux;
  logic [7:0] adc_main, adc_aux;
  logic [2:0] row_sel;
  logic       mux_off, load_n, ser_clk;
  logic [7:0] msg_data;
  logic       msg_valid, msg_ready;
  logic       chg_irq, irq_ack;
  logic [3:0] chg_idx;
  logic [7:0] chg_val;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  panel_scanner u0 (
    .clk(clk), .rst_n(rst_n), .ser_main(ser_main), .ser_aux(ser_aux),
    .adc_main(adc_main), .adc_aux(adc_aux), .row_sel(row_sel), .mux_off(mux_off),
    .load_n(load_n), .ser_clk(ser_clk), .msg_data(msg_data), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .chg_irq(chg_irq), .irq_ack(irq_ack),
    .chg_idx(chg_idx), .chg_val(chg_val)
  );

  // panel model: four switch rows per panel, one pot per panel
  logic [7:0] pm_sw_m [4];
  logic [7:0] pm_sw_a [4];
  logic [7:0] pm_pot_m, pm_pot_a;
  logic [7:0] sr_m = 8'h00, sr_a = 8'h00;

  always @(negedge load_n or posedge ser_clk) begin
    if (!load_n) begin
      sr_m <= pm_sw_m[row_sel[1:0]];
      sr_a <= pm_sw_a[row_sel[1:0]];
    end else begin
      sr_m <= {sr_m[6:0], 1'b0};
      sr_a <= {sr_a[6:0], 1'b0};
    end
  end
  assign ser_main = sr_m[7];
  assign ser_aux  = sr_a[7];
  assign adc_main = (!mux_off && row_sel == 3'd0) ? pm_pot_m : 8'h00;
  assign adc_aux  = (!mux_off && row_sel == 3'd0) ? pm_pot_a : 8'h00;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(int i);
    if (i < 8) return i[0] ? pm_sw_a[i / 2] : pm_sw_m[i / 2];
    return (i == 8) ? pm_pot_m : pm_pot_a;
  endfunction

  task automatic set_byte(input int i, input logic [7:0] v);
    if (i < 8) begin
      if (i[0]) pm_sw_a[i / 2] = v;
      else      pm_sw_m[i / 2] = v;
    end else if (i == 8) pm_pot_m = v;
    else                 pm_pot_a = v;
  endtask

  // load and shift-clock observation over the first startup rows
  int ld_total = 0;
  int rise_cnt = 0;
  always @(posedge ser_clk) rise_cnt++;
  always @(negedge load_n) begin
    if (ld_total > 0 && ld_total < 9)
      check(rise_cnt == 8, "R3 clocks per row", rise_cnt, 8);
    if (ld_total < 9)
      check(row_sel == 3'(ld_total % 4), "R1 row order", row_sel, ld_total % 4);
    if (ld_total < 9)
      check(ser_clk == 1'b0, "R2 clock low in load", ser_clk, 0);
    rise_cnt = 0;
    ld_total++;
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++;
      $display("FAIL watchdog all-reqs actual=%0d expected=<150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic get_report(input string tag);
    int got = 0;
    int cyc = 0;
    bit irq_seen = 0;
    while (got < 11 && cyc < 4000) begin
      @(negedge clk);
      cyc++;
      if (chg_irq) irq_seen = 1;
      if (msg_valid && cyc[0]) begin
        check(msg_data == (got < 10 ? exp_byte(got) : 8'hFF), tag, msg_data,
              got < 10 ? exp_byte(got) : 8'hFF);
        got++;
      end
      msg_ready = cyc[0];
    end
    check(got == 11, "R7 byte count", got, 11);
    @(negedge clk);
    msg_ready = 1'b0;
    check(!msg_valid, "R7 valid low after terminator", msg_valid, 0);
    check(!irq_seen, "R7 no irq before message end", irq_seen, 0);
  endtask

  task automatic wait_irq(input int maxc, output bit seen);
    seen = 0;
    for (int c = 0; c < maxc && !seen; c++) begin
      @(negedge clk);
      if (chg_irq) seen = 1;
    end
  endtask

  task automatic do_ack(input string tag);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    check(!chg_irq, tag, chg_irq, 0);
  endtask

  // change vectors: {image index, new value}
  localparam logic [11:0] CHG_VEC [6] = '{
    {4'd2, 8'hA5}, {4'd5, 8'h3C}, {4'd8, 8'h7E},
    {4'd9, 8'h01}, {4'd0, 8'h00}, {4'd7, 8'hFF}
  };

  initial begin
    bit seen;
    rst_n = 1'b0; msg_ready = 1'b0; irq_ack = 1'b0;
    pm_sw_m = '{8'h11, 8'h22, 8'h33, 8'h44};
    pm_sw_a = '{8'h55, 8'h66, 8'h77, 8'h88};
    pm_pot_m = 8'h9A; pm_pot_a = 8'hBC;
    repeat (3) @(negedge clk);
    // R8 reset state
    check(load_n == 1'b1, "R8 load_n in reset", load_n, 1);
    check(ser_clk == 1'b0, "R8 ser_clk in reset", ser_clk, 0);
    check(mux_off == 1'b1, "R8 mux_off in reset", mux_off, 1);
    check(chg_irq == 1'b0, "R8 irq in reset", chg_irq, 0);
    check(msg_valid == 1'b0, "R8 msg_valid in reset", msg_valid, 0);
    rst_n = 1'b1;

    // R7 startup message, R4 pot bytes 8 and 9, R3 bit order in row bytes
    get_report("R7 startup byte");

    // R5 table of single changes
    for (int v = 0; v < 6; v++) begin
      set_byte(int'(CHG_VEC[v][11:8]), CHG_VEC[v][7:0]);
      wait_irq(1000, seen);
      check(seen, "R5 irq raised", seen, 1);
      check(chg_idx == CHG_VEC[v][11:8], "R5 index", chg_idx, CHG_VEC[v][11:8]);
      check(chg_val == CHG_VEC[v][7:0], "R5 value", chg_val, CHG_VEC[v][7:0]);
      do_ack("R6 ack clears");
    end

    // R6 hold without ack
    set_byte(4, 8'h5A);
    wait_irq(1000, seen);
    check(seen, "R6 irq raised", seen, 1);
    repeat (400) @(negedge clk);
    check(chg_irq, "R6 irq held", chg_irq, 1);
    check(chg_idx == 4'd4, "R6 index held", chg_idx, 4);
    check(chg_val == 8'h5A, "R6 value held", chg_val, 8'h5A);
    do_ack("R6 ack clears after hold");

    // R5/R6 main and aux of one row change together: main first, aux not lost
    set_byte(2, 8'hC3);
    set_byte(3, 8'h0F);
    wait_irq(1000, seen);
    check(seen && chg_idx == 4'd2, "R5 main first", chg_idx, 2);
    check(chg_val == 8'hC3, "R5 main value", chg_val, 8'hC3);
    repeat (300) @(negedge clk);
    do_ack("R6 ack first of pair");
    wait_irq(1000, seen);
    check(seen && chg_idx == 4'd3, "R6 aux reported after ack", chg_idx, 3);
    check(chg_val == 8'h0F, "R6 aux value", chg_val, 8'h0F);
    do_ack("R6 ack second of pair");

    // R9 quiet panel
    seen = 0;
    for (int c = 0; c < 500; c++) begin
      @(negedge clk);
      if (chg_irq) seen = 1;
    end
    check(!seen, "R9 no irq without change", seen, 0);

    // R8 reset in mid-run, startup message rebuilt from fresh readings
    set_byte(6, 8'h42);
    set_byte(9, 8'h24);
    repeat (37) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(load_n == 1'b1 && ser_clk == 1'b0, "R8 pins idle in reset", {load_n, ser_clk}, 2'b10);
    check(!chg_irq && !msg_valid, "R8 irq and valid low", {chg_irq, msg_valid}, 0);
    rst_n = 1'b1;
    get_report("R8 message after reset");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule